// File: doc/BRIEF.md
# NAND Flash Operation Launch and Completion Block

This block is the register front end that a processor uses to drive single operations on a NAND flash port. Software writes a flash command word, a flash address and a buffer selection into 16-bit registers. It then launches one operation by writing a one-hot code into the second control register. There are six operations: command cycle, address cycle, page program (data in), page read (data out), identifier read and status read. A flash-side sequencer stub stands in for the flash, with a fixed latency per operation class. When the operation ends, a sticky done flag is set in bit 15 of the second control register. That flag drives the interrupt line unless the mask bit in the first control register is set.

The sequencer has three states. In SQ_IDLE it waits. An accepted launch moves it to SQ_RUN (IDLE->RUN, "launch"), and a soft-reset request moves it to SQ_SRST (IDLE->SRST, "reset request"). From SQ_RUN it returns to SQ_IDLE when its latency counter expires ("finish"). A soft-reset request moves it from SQ_RUN to SQ_SRST ("abort"). SQ_SRST returns to SQ_IDLE when the reset countdown expires ("reset done"). A separate protection machine has three states. WP_LOCKED is the reset state. It moves to WP_OPEN on unlock ("unlock") and to WP_TIGHT on lock-tight ("freeze"). From WP_OPEN it returns to WP_LOCKED on lock ("relock") or moves to WP_TIGHT ("freeze"). WP_TIGHT is left only by hardware reset. Programming is permitted only while the protection machine is open and the flash address lies inside an inclusive block window.

Register word addresses (reg_addr): 0 flash command, 1 flash address, 2 buffer select, 3 control 1, 4 control 2, 5 protection, 6 window low, 7 window high, 8 spare size. Unlisted addresses read zero and ignore writes.

Top module: `nand_op_ctrl`

## Requirements
- R1: After hardware reset: control 1 reads 0x0010 (interrupt masked), control 2 reads 0x0000, protection reads 0x0002 (locked), buffer select reads 0x0000, and irq, chip_en and wr_permit are low.
- R2: A write to control 2 launches an operation when the sequencer is idle and exactly one of bits [5:0] is set. The bits are: bit0 command, bit1 address, bit2 page program, bit3 page read, bit4 identifier, bit5 status. While it runs, op_active and control 2 bits [5:0] show that code. Both read zero once it ends.
- R3: The edge that sets the done flag (control 2 bit 15) and ends op_active comes SHORT_LAT clock edges after the accepting edge for command, address, identifier and status operations. For page program and page read it comes PAGE_LAT edges after.
- R4: The done flag stays set until a control 2 write with bit 15 at zero. Writing bit 15 as one never sets it.
- R5: irq is high exactly when the done flag is set and control 1 bit 4 (mask) is zero.
- R6: A control 2 write is ignored as a launch in three cases: its bits [5:0] are all zero, more than one of them is set, or an operation is still running. The running operation keeps its code and its completion time.
- R7: Launching page program, page read, identifier or status clears buffer select bits [2:0] (buffer index) and keeps bits [6:5]. Command and address launches leave buffer select unchanged.
- R8: A control 1 write with bit 6 set starts a soft reset. Bit 6 then reads one for RST_LAT edges and clears itself. The reset aborts any running operation without setting the done flag, and register writes are ignored while it lasts. At its end, control 1 reads 0x0010, and the done flag, flash command, flash address, buffer select and spare size are zero.
- R9: Protection is controlled by writes to the protection register. Bit0 means lock-tight, bit1 lock and bit2 unlock, with priority in that order. The register reads 0x0002 when locked, 0x0004 when open and 0x0001 when tight. Once tight it ignores writes, and only hardware reset clears it. Soft reset leaves protection and the window untouched.
- R10: wr_permit is high only while protection is open and window low <= flash address <= window high, both bounds inclusive. Window writes are ignored while tight.
- R11: A page-program launch while wr_permit is low is ignored: op_active stays zero and the done flag stays clear.
- R12: chip_sel follows buffer select bits [6:5] and chip_en follows control 1 bit 7. Buffer select keeps only bits [6:5] and [2:0], and control 1 keeps only bits 4, 5, 7, 8 and [11:9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| irq | output | 1 | Completion interrupt |
| op_active | output | 6 | One-hot code of the running operation |
| chip_sel | output | 2 | Active flash chip select |
| chip_en | output | 1 | Flash chip enable |
| wr_permit | output | 1 | Programming allowed for current flash address |

## Verification
Each of the six one-hot launch codes is walked with a nonzero buffer index. This separates the two latency classes and the operations that reset the buffer index from those that keep it. Zero, two-bit and mid-operation launch codes are sent to show that only a lone code from idle starts work. A soft reset is issued in the middle of a page read, which distinguishes an abort from a completion. The protection window is probed just below, at and just above both bounds, and a program launch is attempted while locked, so an off-by-one compare or a missing permit gate shows up.

// File: rtl/nand_op_pkg.sv
package nand_op_pkg;

    localparam int DW  = 16;
    localparam int AW  = 4;
    localparam int OPW = 6;

    // launch code bit positions in control 2
    localparam int OPB_CMD  = 0;
    localparam int OPB_ADR  = 1;
    localparam int OPB_PIN  = 2;
    localparam int OPB_POUT = 3;
    localparam int OPB_ID   = 4;
    localparam int OPB_STS  = 5;

    localparam int C1_MASK = 4;
    localparam int C1_SRST = 6;
    localparam int C1_CE   = 7;
    localparam int C2_DONE = 15;
    localparam int BS_CS   = 5;
    localparam int BS_IDXW = 3;

    localparam logic [DW-1:0]  C1_WMASK = 16'h0FB0;
    localparam logic [DW-1:0]  C1_RESET = 16'h0010;
    localparam logic [DW-1:0]  BS_WMASK = 16'h0067;
    localparam logic [OPW-1:0] IDX_CLR_OPS = 6'b111100;

    typedef enum logic [AW-1:0] {
        RA_FCMD   = 4'd0,
        RA_FADDR  = 4'd1,
        RA_BUFSEL = 4'd2,
        RA_CFG1   = 4'd3,
        RA_CFG2   = 4'd4,
        RA_PROT   = 4'd5,
        RA_WLO    = 4'd6,
        RA_WHI    = 4'd7,
        RA_SPARE  = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_SRST = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        WP_LOCKED = 2'd0,
        WP_OPEN   = 2'd1,
        WP_TIGHT  = 2'd2
    } wp_state_e;

endpackage

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nand_op_pkg::*;
#(
    parameter int SHORT_LAT = 3,
    parameter int PAGE_LAT  = 8,
    parameter int RST_LAT   = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] start_op,
    input  logic           srst_req,
    output logic           busy,
    output logic           srst_busy,
    output logic           finish,
    output logic           srst_done,
    output logic [OPW-1:0] op_out
);

    localparam int MAXL0 = (SHORT_LAT > PAGE_LAT) ? SHORT_LAT : PAGE_LAT;
    localparam int MAXL  = (MAXL0 > RST_LAT) ? MAXL0 : RST_LAT;
    localparam int CW    = $clog2(MAXL + 1);

    seq_state_e     state, nxt_state;
    logic [CW-1:0]  cnt, nxt_cnt;
    logic [OPW-1:0] op_q, nxt_op;
    logic [CW-1:0]  lat_sel;

    always_comb begin
        if (start_op[OPB_PIN] || start_op[OPB_POUT])
            lat_sel = CW'(PAGE_LAT - 1);
        else
            lat_sel = CW'(SHORT_LAT - 1);
    end

    // next-state logic
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_op    = op_q;
        unique case (state)
            SQ_IDLE: begin
                if (srst_req) begin
                    nxt_state = SQ_SRST;
                    nxt_cnt   = CW'(RST_LAT - 1);
                end else if (start) begin
                    nxt_state = SQ_RUN;
                    nxt_cnt   = lat_sel;
                    nxt_op    = start_op;
                end
            end
            SQ_RUN: begin
                if (srst_req) begin
                    nxt_state = SQ_SRST;
                    nxt_cnt   = CW'(RST_LAT - 1);
                    nxt_op    = '0;
                end else if (cnt == '0) begin
                    nxt_state = SQ_IDLE;
                    nxt_op    = '0;
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            SQ_SRST: begin
                if (cnt == '0)
                    nxt_state = SQ_IDLE;
                else
                    nxt_cnt = cnt - 1'b1;
            end
            default: begin
                nxt_state = SQ_IDLE;
                nxt_cnt   = '0;
                nxt_op    = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            op_q  <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            op_q  <= nxt_op;
        end
    end

    // outputs
    always_comb begin
        busy      = (state == SQ_RUN);
        srst_busy = (state == SQ_SRST);
        finish    = (state == SQ_RUN) && (cnt == '0) && !srst_req;
        srst_done = (state == SQ_SRST) && (cnt == '0);
        op_out    = (state == SQ_RUN) ? op_q : '0;
    end

endmodule

// File: rtl/nand_wp_guard.sv
module nand_wp_guard
    import nand_op_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prot_we,
    input  logic [2:0]    prot_code,
    input  logic          lo_we,
    input  logic          hi_we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] blk,
    output logic [2:0]    prot_rd,
    output logic [DW-1:0] win_lo,
    output logic [DW-1:0] win_hi,
    output logic          permit,
    output logic          tight
);

    wp_state_e state, nxt_state;
    logic      in_window;

    // next-state logic: tight beats lock beats unlock
    always_comb begin
        nxt_state = state;
        unique case (state)
            WP_LOCKED: begin
                if (prot_we && prot_code[0])      nxt_state = WP_TIGHT;
                else if (prot_we && prot_code[1]) nxt_state = WP_LOCKED;
                else if (prot_we && prot_code[2]) nxt_state = WP_OPEN;
            end
            WP_OPEN: begin
                if (prot_we && prot_code[0])      nxt_state = WP_TIGHT;
                else if (prot_we && prot_code[1]) nxt_state = WP_LOCKED;
            end
            WP_TIGHT: nxt_state = WP_TIGHT;
            default:  nxt_state = WP_LOCKED;
        endcase
    end

    // state register and window bounds
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= WP_LOCKED;
            win_lo <= '0;
            win_hi <= '0;
        end else begin
            state <= nxt_state;
            if (lo_we && state != WP_TIGHT) win_lo <= wdata;
            if (hi_we && state != WP_TIGHT) win_hi <= wdata;
        end
    end

    // outputs
    always_comb begin
        in_window = (blk >= win_lo) && (blk <= win_hi);
        permit    = (state == WP_OPEN) && in_window;
        tight     = (state == WP_TIGHT);
        unique case (state)
            WP_OPEN:  prot_rd = 3'b100;
            WP_TIGHT: prot_rd = 3'b001;
            default:  prot_rd = 3'b010;
        endcase
    end

endmodule

// File: rtl/nand_op_ctrl.sv
module nand_op_ctrl
    import nand_op_pkg::*;
#(
    parameter int SHORT_LAT = 3,
    parameter int PAGE_LAT  = 8,
    parameter int RST_LAT   = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           irq,
    output logic [OPW-1:0] op_active,
    output logic [1:0]     chip_sel,
    output logic           chip_en,
    output logic           wr_permit
);

    logic [DW-1:0]  fcmd_q, faddr_q, bufsel_q, cfg1_q, spare_q;
    logic           done_q;
    logic           seq_busy, srst_busy, seq_finish, srst_done;
    logic           wr_ok, start_ok, srst_req;
    logic           wr_fcmd, wr_faddr, wr_bufsel, wr_cfg1, wr_cfg2;
    logic           wr_prot, wr_wlo, wr_whi, wr_spare;
    logic [OPW-1:0] start_code;
    logic [2:0]     prot_rd;
    logic [DW-1:0]  win_lo, win_hi;
    logic           prot_tight;

    // write decode; everything is frozen during a soft reset
    always_comb begin
        wr_ok     = reg_we && !srst_busy;
        wr_fcmd   = wr_ok && (reg_addr == RA_FCMD);
        wr_faddr  = wr_ok && (reg_addr == RA_FADDR);
        wr_bufsel = wr_ok && (reg_addr == RA_BUFSEL);
        wr_cfg1   = wr_ok && (reg_addr == RA_CFG1);
        wr_cfg2   = wr_ok && (reg_addr == RA_CFG2);
        wr_prot   = wr_ok && (reg_addr == RA_PROT);
        wr_wlo    = wr_ok && (reg_addr == RA_WLO);
        wr_whi    = wr_ok && (reg_addr == RA_WHI);
        wr_spare  = wr_ok && (reg_addr == RA_SPARE);
        start_code = reg_wdata[OPW-1:0];
        start_ok  = wr_cfg2 && !seq_busy && ($countones(start_code) == 1)
                    && (!start_code[OPB_PIN] || wr_permit);
        srst_req  = wr_cfg1 && reg_wdata[C1_SRST];
    end

    nand_op_seq #(
        .SHORT_LAT (SHORT_LAT),
        .PAGE_LAT  (PAGE_LAT),
        .RST_LAT   (RST_LAT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_ok),
        .start_op  (start_code),
        .srst_req  (srst_req),
        .busy      (seq_busy),
        .srst_busy (srst_busy),
        .finish    (seq_finish),
        .srst_done (srst_done),
        .op_out    (op_active)
    );

    nand_wp_guard u_wp (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_we   (wr_prot),
        .prot_code (reg_wdata[2:0]),
        .lo_we     (wr_wlo),
        .hi_we     (wr_whi),
        .wdata     (reg_wdata),
        .blk       (faddr_q),
        .prot_rd   (prot_rd),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .permit    (wr_permit),
        .tight     (prot_tight)
    );

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcmd_q   <= '0;
            faddr_q  <= '0;
            bufsel_q <= '0;
            cfg1_q   <= C1_RESET;
            spare_q  <= '0;
            done_q   <= 1'b0;
        end else if (srst_done) begin
            fcmd_q   <= '0;
            faddr_q  <= '0;
            bufsel_q <= '0;
            cfg1_q   <= C1_RESET;
            spare_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            if (wr_fcmd)   fcmd_q  <= reg_wdata;
            if (wr_faddr)  faddr_q <= reg_wdata;
            if (wr_cfg1)   cfg1_q  <= reg_wdata & C1_WMASK;
            if (wr_spare)  spare_q <= reg_wdata;
            if (wr_bufsel)
                bufsel_q <= reg_wdata & BS_WMASK;
            else if (start_ok && ((start_code & IDX_CLR_OPS) != '0))
                bufsel_q[BS_IDXW-1:0] <= '0;
            if (seq_finish)
                done_q <= 1'b1;
            else if (wr_cfg2 && !reg_wdata[C2_DONE])
                done_q <= 1'b0;
        end
    end

    // read mux and pin outputs
    always_comb begin
        unique case (reg_addr)
            RA_FCMD:   reg_rdata = fcmd_q;
            RA_FADDR:  reg_rdata = faddr_q;
            RA_BUFSEL: reg_rdata = bufsel_q;
            RA_CFG1:   reg_rdata = cfg1_q | (DW'(srst_busy) << C1_SRST);
            RA_CFG2:   reg_rdata = {done_q, {(DW-1-OPW){1'b0}}, op_active};
            RA_PROT:   reg_rdata = {{(DW-3){1'b0}}, prot_rd};
            RA_WLO:    reg_rdata = win_lo;
            RA_WHI:    reg_rdata = win_hi;
            RA_SPARE:  reg_rdata = spare_q;
            default:   reg_rdata = '0;
        endcase
        irq      = done_q && !cfg1_q[C1_MASK];
        chip_sel = bufsel_q[BS_CS+1:BS_CS];
        chip_en  = cfg1_q[C1_CE];
    end

endmodule

// File: rtl/nand_op_ctrl_chk.sv
module nand_op_ctrl_chk
    import nand_op_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [OPW-1:0] op_active,
    input logic           irq,
    input logic           wr_permit,
    input logic           done_q,
    input logic           seq_finish,
    input logic           srst_busy,
    input logic           prot_tight,
    input logic           start_ok,
    input logic [OPW-1:0] start_code
);

    a_r2_onehot_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_active));

    a_r6_op_held: assert property (@(posedge clk) disable iff (!rst_n)
        (op_active != '0) |=> (op_active == '0 || $stable(op_active)));

    a_r3_finish_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        seq_finish |=> done_q);

    a_r5_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_q);

    a_r8_reset_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> (op_active == '0));

    a_r9_tight_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        prot_tight |=> prot_tight);

    a_r11_prog_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && start_code[OPB_PIN]) |-> wr_permit);

    a_r10_tight_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        prot_tight |-> !wr_permit);

endmodule

bind nand_op_ctrl nand_op_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_active  (op_active),
    .irq        (irq),
    .wr_permit  (wr_permit),
    .done_q     (done_q),
    .seq_finish (seq_finish),
    .srst_busy  (srst_busy),
    .prot_tight (prot_tight),
    .start_ok   (start_ok),
    .start_code (start_code)
);

// File: tb/nand_op_ctrl_tb_top.sv
`timescale 1ns/1ps
module nand_op_ctrl_tb_top;

    localparam int SHORT = 3;
    localparam int PAGE  = 8;
    localparam int RSTL  = 5;

    localparam logic [3:0] A_FCMD = 4'd0, A_FADDR = 4'd1, A_BUF = 4'd2, A_C1 = 4'd3,
                           A_C2 = 4'd4, A_PROT = 4'd5, A_WLO = 4'd6, A_WHI = 4'd7,
                           A_SPARE = 4'd8;

    // vector: [15] index cleared, [12:8] latency, [5:0] launch code
    localparam logic [15:0] VEC [6] = '{
        {1'b0, 2'b0, 5'(SHORT), 2'b0, 6'h01},
        {1'b0, 2'b0, 5'(SHORT), 2'b0, 6'h02},
        {1'b1, 2'b0, 5'(PAGE),  2'b0, 6'h04},
        {1'b1, 2'b0, 5'(PAGE),  2'b0, 6'h08},
        {1'b1, 2'b0, 5'(SHORT), 2'b0, 6'h10},
        {1'b1, 2'b0, 5'(SHORT), 2'b0, 6'h20}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic [5:0]  op_active;
    logic [1:0]  chip_sel;
    logic        chip_en;
    logic        wr_permit;

    int checks = 0;
    int fails  = 0;
    bit over   = 1'b0;

    always #2 clk = ~clk;

    nand_op_ctrl #(.SHORT_LAT(SHORT), .PAGE_LAT(PAGE), .RST_LAT(RSTL)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .op_active(op_active), .chip_sel(chip_sel), .chip_en(chip_en),
        .wr_permit(wr_permit)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [15:0] exp);
        logic [15:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    // called at a negedge; returns at the negedge after the capturing edge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic hw_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!over) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        hw_reset();

        // R1 reset state
        rdchk("R1 cfg1", A_C1, 16'h0010);
        rdchk("R1 cfg2", A_C2, 16'h0000);
        rdchk("R1 prot", A_PROT, 16'h0002);
        rdchk("R1 bufsel", A_BUF, 16'h0000);
        check("R1 pins", {13'b0, irq, chip_en, wr_permit}, 16'h0);

        // R12 field masks and pins
        wr(A_BUF, 16'hFFFF);
        rdchk("R12 bufsel mask", A_BUF, 16'h0067);
        check("R12 chip_sel", {14'b0, chip_sel}, 16'h0003);
        wr(A_C1, 16'hFFBF);
        rdchk("R12 cfg1 mask", A_C1, 16'h0FB0);
        check("R12 chip_en", {15'b0, chip_en}, 16'h0001);
        wr(A_C1, 16'h0010);
        check("R12 chip_en off", {15'b0, chip_en}, 16'h0000);

        // R11 program while locked is ignored
        wr(A_C2, 16'h0004);
        check("R11 no op", {10'b0, op_active}, 16'h0);
        repeat (PAGE + 1) @(negedge clk);
        rdchk("R11 no done", A_C2, 16'h0000);

        // R10 window and R9 states
        wr(A_WLO, 16'h0010);
        wr(A_WHI, 16'h0020);
        wr(A_FADDR, 16'h0018);
        check("R10 locked no permit", {15'b0, wr_permit}, 16'h0);
        wr(A_PROT, 16'h0004);
        rdchk("R9 open", A_PROT, 16'h0004);
        check("R10 inside", {15'b0, wr_permit}, 16'h1);
        wr(A_FADDR, 16'h0021);
        check("R10 above hi", {15'b0, wr_permit}, 16'h0);
        wr(A_FADDR, 16'h000F);
        check("R10 below lo", {15'b0, wr_permit}, 16'h0);
        wr(A_FADDR, 16'h0020);
        check("R10 at hi", {15'b0, wr_permit}, 16'h1);
        wr(A_FADDR, 16'h0010);
        check("R10 at lo", {15'b0, wr_permit}, 16'h1);
        wr(A_PROT, 16'h0006);
        rdchk("R9 lock beats unlock", A_PROT, 16'h0002);
        check("R10 relocked", {15'b0, wr_permit}, 16'h0);
        wr(A_PROT, 16'h0004);
        wr(A_FADDR, 16'h0018);

        // R2 R3 R7 vector walk
        for (int i = 0; i < 6; i++) begin
            logic [15:0] v;
            int lat;
            v = VEC[i];
            lat = int'(v[12:8]);
            wr(A_BUF, 16'h0045);
            wr(A_C2, {10'b0, v[5:0]});
            check("R2 op_active", {10'b0, op_active}, {10'b0, v[5:0]});
            rdchk("R2 cfg2 running", A_C2, {10'b0, v[5:0]});
            repeat (lat - 1) @(negedge clk);
            rdchk("R3 not yet done", A_C2, {10'b0, v[5:0]});
            @(negedge clk);
            rdchk("R3 done on time", A_C2, 16'h8000);
            check("R2 op ended", {10'b0, op_active}, 16'h0);
            rdchk("R7 buffer index", A_BUF, v[15] ? 16'h0040 : 16'h0045);
            check("R5 masked irq", {15'b0, irq}, 16'h0);
        end

        // R5 mask, R4 sticky done
        wr(A_C1, 16'h0000);
        check("R5 unmasked irq", {15'b0, irq}, 16'h1);
        wr(A_C1, 16'h0010);
        check("R5 remasked irq", {15'b0, irq}, 16'h0);
        wr(A_C1, 16'h0000);
        wr(A_C2, 16'h8000);
        rdchk("R4 write one keeps", A_C2, 16'h8000);
        wr(A_C2, 16'h0000);
        rdchk("R4 write zero clears", A_C2, 16'h0000);
        check("R5 irq after clear", {15'b0, irq}, 16'h0);
        wr(A_C2, 16'h8000);
        rdchk("R4 write one never sets", A_C2, 16'h0000);

        // R6 ignored launches
        wr(A_C2, 16'h0003);
        check("R6 two bits", {10'b0, op_active}, 16'h0);
        wr(A_C2, 16'h0020);
        wr(A_C2, 16'h0001);
        check("R6 busy keeps op", {10'b0, op_active}, 16'h0020);
        repeat (SHORT - 2) @(negedge clk);
        rdchk("R6 still running", A_C2, 16'h0020);
        @(negedge clk);
        rdchk("R6 original timing", A_C2, 16'h8000);
        check("R5 irq done", {15'b0, irq}, 16'h1);
        repeat (SHORT + 1) @(negedge clk);
        check("R6 no late op", {10'b0, op_active}, 16'h0);

        // R8 soft reset aborts a page read
        wr(A_FCMD, 16'h0070);
        wr(A_SPARE, 16'h0040);
        wr(A_BUF, 16'h0023);
        wr(A_C2, 16'h0008);
        wr(A_C1, 16'h0040);
        rdchk("R8 bit reads one", A_C1, 16'h0040);
        check("R8 op aborted", {10'b0, op_active}, 16'h0);
        wr(A_FCMD, 16'h00AA);
        repeat (RSTL - 2) @(negedge clk);
        rdchk("R8 still resetting", A_C1, 16'h0040);
        rdchk("R8 write ignored", A_FCMD, 16'h0070);
        @(negedge clk);
        rdchk("R8 cfg1 default", A_C1, 16'h0010);
        rdchk("R8 fcmd cleared", A_FCMD, 16'h0000);
        rdchk("R8 spare cleared", A_SPARE, 16'h0000);
        rdchk("R8 bufsel cleared", A_BUF, 16'h0000);
        repeat (PAGE) @(negedge clk);
        rdchk("R8 no done", A_C2, 16'h0000);
        rdchk("R9 prot kept", A_PROT, 16'h0004);
        rdchk("R9 window kept", A_WLO, 16'h0010);

        // R9 tight
        wr(A_PROT, 16'h0001);
        rdchk("R9 tight", A_PROT, 16'h0001);
        wr(A_PROT, 16'h0004);
        rdchk("R9 tight sticks", A_PROT, 16'h0001);
        wr(A_WLO, 16'h0000);
        rdchk("R10 window frozen", A_WLO, 16'h0010);
        wr(A_FADDR, 16'h0018);
        check("R10 tight no permit", {15'b0, wr_permit}, 16'h0);
        hw_reset();
        rdchk("R9 hw reset unlocks tight", A_PROT, 16'h0002);
        rdchk("R1 window reset", A_WLO, 16'h0000);

        over = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule